// File: doc/BRIEF.md
# Link Receiver Event Buffer

This block sits behind the deserializer of one front-end readout link. It accepts a stream of 16-bit words, one per valid cycle, and checks that each event arrives as a well-formed frame: a header word, any number of data words, and a trailer word. Well-placed words go into a deep word FIFO. The far side of the FIFO drops data words that carry no hits and packs the surviving words in pairs into 32-bit entries of a dual-port event memory, which is used as a ring.

When the trailer of an event leaves the FIFO, the block appends a descriptor for the event to a descriptor queue. The event-ready status flag stays high while at least one descriptor waits. The controller polls that flag, reads the oldest descriptor, fetches the event words through a separate read port, and then acknowledges. The acknowledge removes the descriptor and frees the event's memory. The link is never stalled. If the FIFO runs short of room, words are dropped, a sticky overflow flag is set and the affected event is marked corrupt.

Top module: `lrx_event_buffer`

## Requirements
- R1: Each word carries a type tag in bits 15:14 and a payload in bits 13:0. Tag 2'b01 is a header, 2'b00 is data, 2'b10 is a trailer and 2'b11 is reserved.
- R2: A data word, trailer or reserved word outside a frame is dropped and sets the sticky `err_format`. A header or reserved word inside a frame is also dropped and sets `err_format`, and it also sets the error bit of that event's descriptor.
- R3: A data word whose 14-bit payload is zero is never written to the event memory.
- R4: Surviving data words of an event are paired in arrival order, the first of a pair in bits 15:0 and the second in bits 31:16. An odd last word is written with bits 31:16 zero. Each event's entries follow the previous event's entries at consecutive ring addresses, starting at address 0 after reset.
- R5: A descriptor holds the error bit in bit 31, the number of 32-bit memory entries of the event in bits 30:16, and the start address in bits 15:0. `desc_head` shows the oldest pending descriptor.
- R6: `evt_ready` is high exactly while a descriptor is pending. `host_ack` while `evt_ready` is high removes the oldest descriptor and frees its entries. `host_ack` while `evt_ready` is low has no effect.
- R7: When the descriptor queue is full, or a memory write is needed and the memory is full, the drain side holds the word in the FIFO and resumes after an acknowledge. No word is lost while the FIFO has room.
- R8: A header is accepted only while the FIFO holds at most DEPTH-2 words. Otherwise the whole frame is discarded and `err_overflow` is set. A data word arriving while the FIFO holds DEPTH-1 or more words is dropped, sets `err_overflow` and marks the event in error. A trailer is always accepted. `err_overflow` is sticky.
- R9: `host_rd_data` returns the event memory entry at `host_rd_addr` one clock after the address is presented.
- R10: After reset, `evt_ready`, `err_format`, `err_overflow` and `host_rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Link word valid |
| in_word | input | 16 | Link word: tag in bits 15:14, payload in bits 13:0 |
| host_ack | input | 1 | Acknowledge and release of the oldest event |
| host_rd_addr | input | MEM_AW | Event memory read address |
| evt_ready | output | 1 | Event-ready status flag |
| desc_head | output | 32 | Oldest pending descriptor |
| host_rd_data | output | 32 | Event memory read data, one cycle latency |
| err_format | output | 1 | Sticky frame format error |
| err_overflow | output | 1 | Sticky FIFO overflow error |

## Verification
The bench builds the block with an 8-word FIFO, a 16-entry event memory and a 4-entry descriptor queue. With these sizes, a handful of unacknowledged short frames fills the descriptor queue, and a following frame then overflows the FIFO within a few cycles, which exercises both the data-drop rule and the whole-frame discard. Two events of seven entries each bring the memory-full stall within reach, and the ring wraps several times during the random phase.

// File: rtl/lrx_pkg.sv
// Shared definitions for the link receiver event buffer: word tag codes,
// frame checker states and the descriptor field layout.
package lrx_pkg;

    localparam int WORD_W      = 16;
    localparam int PAYLOAD_W   = 14;
    localparam int ENTRY_W     = 32;
    localparam int DESC_CNT_W  = 15;
    localparam int DESC_ADR_W  = 16;
    localparam int DESC_CNT_LSB = 16;

    typedef enum logic [1:0] {
        TAG_DATA = 2'b00,
        TAG_HEAD = 2'b01,
        TAG_TAIL = 2'b10,
        TAG_RSVD = 2'b11
    } tag_e;

    typedef enum logic [1:0] {
        CK_IDLE  = 2'b00,
        CK_FRAME = 2'b01,
        CK_SKIP  = 2'b10
    } ck_state_e;

endpackage

// File: rtl/lrx_sync_fifo.sv
// Synchronous FIFO with a combinational head output and an occupancy count.
// Assumes: DEPTH = 2**AW; a push while full and a pop while empty are ignored.
module lrx_sync_fifo #(
    parameter int WIDTH = 17,
    parameter int AW    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [AW:0]      level
);
    localparam int DEPTH = 1 << AW;
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    logic [WIDTH-1:0] store [DEPTH];
    logic [AW-1:0]    wp_q, rp_q;
    logic [AW:0]      cnt_q;
    logic             do_push, do_pop;

    assign do_push = push && (cnt_q != FULL_LVL);
    assign do_pop  = pop  && (cnt_q != '0);
    assign dout    = store[rp_q];
    assign level   = cnt_q;

    // Write the storage array on an accepted push.
    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wp_q] <= din;
        end
    end

    // Advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= wp_q + 1'b1;
            if (do_pop)  rp_q <= rp_q + 1'b1;
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/lrx_dpram.sv
// Dual-port event memory: one write port, one registered read port.
// Assumes: read data is zero after reset until the first read; same-address
// read and write in one cycle return the old entry.
module lrx_dpram #(
    parameter int AW = 10,
    parameter int W  = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Store one entry per write strobe.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Registered read toward the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else begin
            rdata <= mem[raddr];
        end
    end

endmodule

// File: rtl/lrx_frame_check.sv
// Frame checker in front of the word FIFO. It tracks header/data/trailer
// order, drops misplaced words, applies the FIFO room rules and tags each
// trailer with the event's error bit (bit 16 of the FIFO entry).
// Assumes: fifo_level is the registered occupancy at the start of the cycle.
module lrx_frame_check
    import lrx_pkg::*;
#(
    parameter int FIFO_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [WORD_W-1:0]  in_word,
    input  logic [FIFO_AW:0]   fifo_level,
    output logic               push,
    output logic [WORD_W:0]    push_data,
    output logic               err_format,
    output logic               err_overflow
);
    localparam int FIFO_DEPTH = 1 << FIFO_AW;
    localparam logic [FIFO_AW:0] ROOM_LIMIT = (FIFO_AW+1)'(FIFO_DEPTH - 1);

    ck_state_e st_q, st_d;
    logic      everr_q, everr_d;
    logic      fmt_q, ovf_q, fmt_set, ovf_set;
    tag_e      tag;
    logic      room;

    assign tag  = tag_e'(in_word[WORD_W-1 -: 2]);
    assign room = fifo_level < ROOM_LIMIT;

    // Decide acceptance, error events and next frame state for this word.
    always_comb begin
        st_d      = st_q;
        everr_d   = everr_q;
        push      = 1'b0;
        push_data = {1'b0, in_word};
        fmt_set   = 1'b0;
        ovf_set   = 1'b0;
        if (in_valid) begin
            case (st_q)
                CK_IDLE: begin
                    if (tag == TAG_HEAD) begin
                        if (room) begin
                            push    = 1'b1;
                            st_d    = CK_FRAME;
                            everr_d = 1'b0;
                        end else begin
                            ovf_set = 1'b1;
                            st_d    = CK_SKIP;
                        end
                    end else begin
                        fmt_set = 1'b1;
                    end
                end
                CK_FRAME: begin
                    case (tag)
                        TAG_DATA: begin
                            if (room) begin
                                push = 1'b1;
                            end else begin
                                ovf_set = 1'b1;
                                everr_d = 1'b1;
                            end
                        end
                        TAG_TAIL: begin
                            push      = 1'b1;
                            push_data = {everr_q, in_word};
                            st_d      = CK_IDLE;
                        end
                        default: begin
                            fmt_set = 1'b1;
                            everr_d = 1'b1;
                        end
                    endcase
                end
                CK_SKIP: begin
                    if (tag == TAG_TAIL) begin
                        st_d = CK_IDLE;
                    end else if (tag != TAG_DATA) begin
                        fmt_set = 1'b1;
                    end
                end
                default: st_d = CK_IDLE;
            endcase
        end
    end

    // Hold frame state, event error and the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= CK_IDLE;
            everr_q <= 1'b0;
            fmt_q   <= 1'b0;
            ovf_q   <= 1'b0;
        end else begin
            st_q    <= st_d;
            everr_q <= everr_d;
            fmt_q   <= fmt_q | fmt_set;
            ovf_q   <= ovf_q | ovf_set;
        end
    end

    assign err_format   = fmt_q;
    assign err_overflow = ovf_q;

endmodule

// File: rtl/lrx_pack_drain.sv
// Drain side of the word FIFO: zero suppression, pairing into 32-bit ring
// entries, and descriptor generation at each trailer. It also keeps the
// count of ring entries owned by unacknowledged and open events.
// Assumes: no single event needs more entries than the ring holds.
module lrx_pack_drain
    import lrx_pkg::*;
#(
    parameter int MEM_AW  = 10,
    parameter int DESC_AW = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_empty,
    input  logic [WORD_W:0]    fifo_head,
    input  logic [DESC_AW:0]   desc_level,
    input  logic               ack_pop,
    input  logic [MEM_AW:0]    ack_entries,
    output logic               fifo_pop,
    output logic               mem_we,
    output logic [MEM_AW-1:0]  mem_waddr,
    output logic [ENTRY_W-1:0] mem_wdata,
    output logic               desc_push,
    output logic [ENTRY_W-1:0] desc_data
);
    localparam logic [MEM_AW:0]  MEM_FULL  = (MEM_AW+1)'(1 << MEM_AW);
    localparam logic [DESC_AW:0] DESC_FULL = (DESC_AW+1)'(1 << DESC_AW);

    logic [MEM_AW-1:0]  wr_q, start_q;
    logic [MEM_AW:0]    used_q, words_q, words_nx;
    logic [WORD_W-1:0]  half_q;
    logic               half_v_q;
    tag_e               tag;
    logic               hit, mem_room, desc_room;

    assign tag       = tag_e'(fifo_head[WORD_W-1 -: 2]);
    assign hit       = |fifo_head[PAYLOAD_W-1:0];
    assign mem_room  = used_q < MEM_FULL;
    assign desc_room = desc_level < DESC_FULL;
    assign mem_waddr = wr_q;
    assign words_nx  = words_q + {{MEM_AW{1'b0}}, mem_we};
    assign desc_data = {fifo_head[WORD_W], DESC_CNT_W'(words_nx), DESC_ADR_W'(start_q)};

    // Choose pop, memory write and descriptor push for the head word.
    always_comb begin
        fifo_pop  = 1'b0;
        mem_we    = 1'b0;
        desc_push = 1'b0;
        mem_wdata = {fifo_head[WORD_W-1:0], half_q};
        if (!fifo_empty) begin
            case (tag)
                TAG_DATA: begin
                    if (!hit || !half_v_q) begin
                        fifo_pop = 1'b1;
                    end else if (mem_room) begin
                        fifo_pop = 1'b1;
                        mem_we   = 1'b1;
                    end
                end
                TAG_TAIL: begin
                    mem_wdata = {{WORD_W{1'b0}}, half_q};
                    if (desc_room && (!half_v_q || mem_room)) begin
                        fifo_pop  = 1'b1;
                        desc_push = 1'b1;
                        mem_we    = half_v_q;
                    end
                end
                default: fifo_pop = 1'b1;
            endcase
        end
    end

    // Track the open event, the pending half word and the ring write pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q     <= '0;
            start_q  <= '0;
            words_q  <= '0;
            half_q   <= '0;
            half_v_q <= 1'b0;
        end else begin
            if (fifo_pop) begin
                case (tag)
                    TAG_HEAD: begin
                        start_q  <= wr_q;
                        words_q  <= '0;
                        half_v_q <= 1'b0;
                    end
                    TAG_DATA: begin
                        if (hit && !half_v_q) begin
                            half_q   <= fifo_head[WORD_W-1:0];
                            half_v_q <= 1'b1;
                        end else if (mem_we) begin
                            half_v_q <= 1'b0;
                        end
                    end
                    TAG_TAIL: half_v_q <= 1'b0;
                    default: half_v_q <= half_v_q;
                endcase
            end
            if (mem_we) begin
                wr_q <= wr_q + 1'b1;
            end
            if (fifo_pop && tag != TAG_HEAD) begin
                words_q <= words_nx;
            end
        end
    end

    // Count ring entries in use: grow on write, shrink on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            used_q <= '0;
        end else begin
            used_q <= used_q + {{MEM_AW{1'b0}}, mem_we}
                             - (ack_pop ? ack_entries : '0);
        end
    end

endmodule

// File: rtl/lrx_event_buffer.sv
// Link receiver event buffer top: frame checker, word FIFO, drain/packer,
// dual-port event memory and descriptor queue. evt_ready is the status flag
// the controller polls; host_ack releases the oldest event.
// Assumes: MEM_AW <= 14 so counts and addresses fit the descriptor fields.
module lrx_event_buffer
    import lrx_pkg::*;
#(
    parameter int FIFO_AW = 10,
    parameter int MEM_AW  = 10,
    parameter int DESC_AW = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [15:0]       in_word,
    input  logic              host_ack,
    input  logic [MEM_AW-1:0] host_rd_addr,
    output logic              evt_ready,
    output logic [31:0]       desc_head,
    output logic [31:0]       host_rd_data,
    output logic              err_format,
    output logic              err_overflow
);
    logic                fifo_push, fifo_pop, fifo_empty;
    logic [WORD_W:0]     fifo_din, fifo_head;
    logic [FIFO_AW:0]    fifo_level;
    logic                mem_we;
    logic [MEM_AW-1:0]   mem_waddr;
    logic [ENTRY_W-1:0]  mem_wdata;
    logic                desc_push, ack_pop;
    logic [ENTRY_W-1:0]  desc_data;
    logic [DESC_AW:0]    desc_level;

    assign fifo_empty = (fifo_level == '0);
    assign evt_ready  = (desc_level != '0);
    assign ack_pop    = host_ack && evt_ready;

    lrx_frame_check #(.FIFO_AW(FIFO_AW)) u_check (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_word      (in_word),
        .fifo_level   (fifo_level),
        .push         (fifo_push),
        .push_data    (fifo_din),
        .err_format   (err_format),
        .err_overflow (err_overflow)
    );

    lrx_sync_fifo #(.WIDTH(WORD_W+1), .AW(FIFO_AW)) u_word_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fifo_push),
        .din   (fifo_din),
        .pop   (fifo_pop),
        .dout  (fifo_head),
        .level (fifo_level)
    );

    lrx_pack_drain #(.MEM_AW(MEM_AW), .DESC_AW(DESC_AW)) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .fifo_empty  (fifo_empty),
        .fifo_head   (fifo_head),
        .desc_level  (desc_level),
        .ack_pop     (ack_pop),
        .ack_entries (desc_head[DESC_CNT_LSB +: MEM_AW+1]),
        .fifo_pop    (fifo_pop),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata),
        .desc_push   (desc_push),
        .desc_data   (desc_data)
    );

    lrx_dpram #(.AW(MEM_AW), .W(ENTRY_W)) u_evt_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we),
        .waddr (mem_waddr),
        .wdata (mem_wdata),
        .raddr (host_rd_addr),
        .rdata (host_rd_data)
    );

    lrx_sync_fifo #(.WIDTH(ENTRY_W), .AW(DESC_AW)) u_desc_q (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (desc_push),
        .din   (desc_data),
        .pop   (ack_pop),
        .dout  (desc_head),
        .level (desc_level)
    );

endmodule

// File: rtl/lrx_event_buffer_sva.sv
// Property checker for lrx_event_buffer, attached through bind.
module lrx_event_buffer_sva #(
    parameter int FIFO_AW = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [15:0]      in_word,
    input logic             fifo_push,
    input logic [FIFO_AW:0] fifo_level,
    input logic             fifo_pop,
    input logic [16:0]      fifo_head,
    input logic             mem_we,
    input logic             desc_push,
    input logic             evt_ready,
    input logic             host_ack,
    input logic             err_format,
    input logic             err_overflow
);
    localparam logic [FIFO_AW:0] FULL_LVL = (FIFO_AW+1)'(1 << FIFO_AW);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_push && fifo_level == FULL_LVL)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |=> err_overflow); // R8

    AST_FMT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_format |=> err_format); // R2

    AST_RSVD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_word[15:14] == 2'b11) |=> err_format); // R2

    AST_ZERO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_pop && fifo_head[15:14] == 2'b00 && fifo_head[13:0] == '0) |-> !mem_we); // R3

    AST_READY_ON_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        desc_push |=> evt_ready); // R6

    AST_ACK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (host_ack && !evt_ready && !desc_push) |=> !evt_ready); // R6

endmodule

bind lrx_event_buffer lrx_event_buffer_sva #(.FIFO_AW(FIFO_AW)) u_sva (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_word      (in_word),
    .fifo_push    (fifo_push),
    .fifo_level   (fifo_level),
    .fifo_pop     (fifo_pop),
    .fifo_head    (fifo_head),
    .mem_we       (mem_we),
    .desc_push    (desc_push),
    .evt_ready    (evt_ready),
    .host_ack     (host_ack),
    .err_format   (err_format),
    .err_overflow (err_overflow)
);

// File: tb/lrx_event_buffer_tb.sv
`timescale 1ns/1ps
module lrx_event_buffer_tb;
    localparam int FAW = 3;
    localparam int MAW = 4;
    localparam int DAW = 2;
    localparam int FD  = 1 << FAW;
    localparam int MD  = 1 << MAW;
    localparam int DD  = 1 << DAW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [15:0]    in_word = '0;
    logic           host_ack = 1'b0;
    logic [MAW-1:0] host_rd_addr = '0;
    logic           evt_ready, err_format, err_overflow;
    logic [31:0]    desc_head, host_rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    lrx_event_buffer #(.FIFO_AW(FAW), .MEM_AW(MAW), .DESC_AW(DAW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .host_ack(host_ack), .host_rd_addr(host_rd_addr), .evt_ready(evt_ready),
        .desc_head(desc_head), .host_rd_data(host_rd_data),
        .err_format(err_format), .err_overflow(err_overflow)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference state
    logic [16:0] fq[$];
    logic [31:0] dq[$];
    int used, wra, mstart, mcnt, cst;
    bit hv, everr, mfmt, movf;
    logic [15:0] half;
    logic [31:0] mmem [MD];
    bit mwr [MD];

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model, one step per rising edge
    always @(posedge clk) begin
        int lvl, dsz;
        logic [16:0] h, pd;
        logic [1:0] t, tg;
        bit pop, we, dpush, push;
        logic [31:0] dword;
        if (!rst_n) begin
            fq.delete(); dq.delete();
            used = 0; wra = 0; mstart = 0; mcnt = 0; cst = 0;
            hv = 0; everr = 0; mfmt = 0; movf = 0; half = '0;
            for (int i = 0; i < MD; i++) mwr[i] = 0;
        end else begin
            lvl = fq.size(); dsz = dq.size();
            pop = 0; we = 0; dpush = 0; push = 0; dword = '0; pd = '0;
            if (lvl > 0) begin
                h = fq[0]; t = h[15:14];
                if (t == 2'b01) begin
                    pop = 1; mstart = wra; mcnt = 0; hv = 0;
                end else if (t == 2'b00) begin
                    if (h[13:0] == 0) pop = 1;
                    else if (!hv) begin pop = 1; half = h[15:0]; hv = 1; end
                    else if (used < MD) begin
                        pop = 1; we = 1; mmem[wra] = {h[15:0], half}; hv = 0;
                    end
                end else if (t == 2'b10) begin
                    if (dsz < DD && (!hv || used < MD)) begin
                        pop = 1; dpush = 1;
                        if (hv) begin we = 1; mmem[wra] = {16'h0000, half}; end
                        dword = {h[16], 15'(mcnt + int'(we)), 16'(mstart)};
                        hv = 0;
                    end
                end else pop = 1;
                if (we) begin mwr[wra] = 1; wra = (wra + 1) % MD; mcnt++; end
            end
            if (in_valid) begin
                tg = in_word[15:14];
                case (cst)
                    0: if (tg == 2'b01) begin
                           if (lvl < FD - 1) begin push = 1; pd = {1'b0, in_word}; cst = 1; everr = 0; end
                           else begin movf = 1; cst = 2; end
                       end else mfmt = 1;
                    1: if (tg == 2'b00) begin
                           if (lvl < FD - 1) begin push = 1; pd = {1'b0, in_word}; end
                           else begin movf = 1; everr = 1; end
                       end else if (tg == 2'b10) begin
                           push = 1; pd = {everr, in_word}; cst = 0;
                       end else begin mfmt = 1; everr = 1; end
                    default: if (tg == 2'b10) cst = 0;
                             else if (tg != 2'b00) mfmt = 1;
                endcase
            end
            if (pop) void'(fq.pop_front());
            if (push) fq.push_back(pd);
            if (host_ack && dsz > 0) begin
                used -= int'(dq[0][30:16]);
                void'(dq.pop_front());
            end
            if (dpush) dq.push_back(dword);
            used += int'(we);
        end
    end

    // Every-cycle comparison against the reference, away from the edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 ready", {31'b0, evt_ready}, {31'b0, dq.size() != 0});
            if (dq.size() != 0) chk("R5 desc", desc_head, dq[0]);
            chk("R2 fmt", {31'b0, err_format}, {31'b0, mfmt});
            chk("R8 ovf", {31'b0, err_overflow}, {31'b0, movf});
        end
    end

    task automatic tick(bit v, logic [15:0] w, bit a);
        @(negedge clk);
        in_valid = v; in_word = w; host_ack = a;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick(0, 16'h0, 0);
    endtask

    task automatic rd(int addr, logic [31:0] exp, string req);
        @(negedge clk);
        in_valid = 0; host_ack = 0; host_rd_addr = MAW'(addr);
        @(negedge clk);
        chk(req, host_rd_data, exp);
    endtask

    task automatic frame(int n, int hit_base);
        tick(1, 16'h4000, 0);
        for (int i = 0; i < n; i++) tick(1, 16'((hit_base + i) & 16'h3FFF), 0);
        tick(1, 16'h8000, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 ready", {31'b0, evt_ready}, 32'h0);
        chk("R10 fmt", {31'b0, err_format}, 32'h0);
        chk("R10 ovf", {31'b0, err_overflow}, 32'h0);
        chk("R10 rdata", host_rd_data, 32'h0);
        rst_n = 1'b1;
        idle(2);

        // R1 R3 R4 R5: H, 5, 0, 7, 9, T -> two entries, zero word dropped
        tick(1, 16'h4000, 0); tick(1, 16'h0005, 0); tick(1, 16'h0000, 0);
        tick(1, 16'h0007, 0); tick(1, 16'h0009, 0); tick(1, 16'h8000, 0);
        idle(4);
        chk("R5 first desc", desc_head, 32'h0002_0000);
        chk("R6 ready after trailer", {31'b0, evt_ready}, 32'h1);
        rd(0, 32'h0007_0005, "R4 pair order");
        rd(1, 32'h0000_0009, "R4 odd pad");

        // R3: frame of empty words only -> zero-entry event
        tick(1, 16'h4000, 0); tick(1, 16'h0000, 0); tick(1, 16'h0000, 0); tick(1, 16'h8000, 0);
        idle(3);
        tick(0, 0, 1); idle(2);
        chk("R3 empty event desc", desc_head, 32'h0000_0002);
        tick(0, 0, 1); idle(2);
        chk("R6 drained", {31'b0, evt_ready}, 32'h0);
        // R6: acknowledge with nothing pending has no effect
        tick(0, 0, 1); tick(1, 16'h4000, 1); tick(1, 16'h8000, 0); idle(3);
        chk("R6 ignored ack", desc_head, 32'h0000_0002);
        tick(0, 0, 1); idle(2);

        // R2: data while idle, then header inside a frame
        tick(1, 16'h0003, 0); idle(2);
        chk("R2 stray data", {31'b0, err_format}, 32'h1);
        tick(1, 16'h4000, 0); tick(1, 16'h0003, 0); tick(1, 16'h4005, 0); tick(1, 16'h8000, 0);
        tick(1, 16'hC000, 0);
        idle(4);
        chk("R2 event err bit", desc_head, 32'h8001_0002);
        rd(2, 32'h0000_0003, "R4 single word");
        tick(0, 0, 1); idle(2);

        // R7: memory-full stall, no loss
        frame(14, 1); frame(14, 20); frame(8, 40);
        idle(10);
        chk("R7 no loss", {31'b0, err_overflow}, 32'h0);
        tick(0, 0, 1); idle(10);
        tick(0, 0, 1); idle(4); tick(0, 0, 1); idle(4);

        // R8: fill descriptor queue, then overflow the FIFO
        for (int k = 0; k < 4; k++) frame(1, k + 1);
        frame(2, 60);
        frame(10, 80);
        frame(2, 100);
        idle(2);
        chk("R8 overflow flag", {31'b0, err_overflow}, 32'h1);
        for (int k = 0; k < 12; k++) begin tick(0, 0, 1); idle(3); end

        // Random traffic with random acknowledges
        for (int f = 0; f < 40; f++) begin
            int n = $urandom_range(0, 6);
            tick(1, 16'h4000, $urandom_range(0, 1));
            for (int i = 0; i < n; i++) begin
                logic [15:0] w = ($urandom_range(0, 2) == 0) ? 16'h0000 : 16'($urandom_range(1, 16'h3FFF));
                if ($urandom_range(0, 15) == 0) w = 16'h4001;
                tick(1, w, $urandom_range(0, 1));
            end
            tick(1, 16'h8000 | 16'(f), $urandom_range(0, 1));
            for (int i = 0; i < $urandom_range(0, 3); i++) tick(0, 0, $urandom_range(0, 1));
        end
        for (int i = 0; i < 60; i++) tick(0, 0, 1);
        idle(2);

        // R9 R4: read back every written entry
        for (int a = 0; a < MD; a++) if (mwr[a]) rd(a, mmem[a], "R9 readback");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule